// File: doc/BRIEF.md
# Carry-Select Adder-Subtractor with Compare Flags

This block is the arithmetic core of an integer ALU. It adds or subtracts two 32-bit operands in one combinational pass and, alongside the result, reports signed overflow, a signed less-than flag and a not-equal flag. It has no clock and no state. Every output follows the current inputs.

The sum is built from 4-bit ripple-carry groups arranged as a carry-select chain. The lowest group ripples from the real carry-in. Each higher group computes its four sum bits and its carry-out twice, once with carry-in 0 and once with carry-in 1. A 2:1 selection then uses the actual carry from the group below. For subtraction, the second operand is passed through an XOR with the subtract control, and the same control feeds the carry-in of the lowest group. This gives the two's-complement difference. The compare flags are read directly off that difference, so the block answers "A < B" and "A != B" when the subtract control is high.

Top module: `csel_addsub`

## Requirements
- R1: With sub_i=0, sum_o equals (a_i + b_i) modulo 2^32.
- R2: With sub_i=1, sum_o equals (a_i - b_i) modulo 2^32.
- R3: ovf_o is 1 exactly when the signed (two's-complement) result of the selected operation lies outside [-2^31, 2^31-1], in both modes.
- R4: With sub_i=1, lt_o is 1 exactly when a_i is less than b_i, both read as signed 32-bit numbers. Examples: 0x80000000 vs 0x7FFFFFFF gives 1; 0x7FFFFFFF vs 0x80000000 gives 0; 0x80000001 vs 0x00000001 gives 1.
- R5: With sub_i=1, ne_o is 1 exactly when a_i differs from b_i.
- R6: With sub_i=0, lt_o equals sum_o[31] XOR ovf_o, and ne_o is 1 exactly when sum_o is nonzero.
- R7: Carries cross every 4-bit group boundary correctly. For example, 0x0000000F+1 gives 0x00000010, 0x0FFFFFFF+1 gives 0x10000000, and 0xFFFFFFFF+1 gives 0 with no overflow.
- R8: 0x7FFFFFFF+2 gives 0x80000001 with overflow set. 0x80000000+0x7FFFFFFF gives 0xFFFFFFFF with overflow clear.
- R9: 0x80000000-1 gives 0x7FFFFFFF with overflow set. 0-0x80000000 gives 0x80000000 with overflow set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| sum_o | output | 32 | Sum or difference |
| ovf_o | output | 1 | Signed overflow of the selected operation |
| lt_o | output | 1 | Signed less-than flag (result bit 31 XOR overflow) |
| ne_o | output | 1 | Not-equal flag (OR of all result bits) |

## Verification
The in-line immediate assertions assume that all three inputs carry known 0/1 values. They are gated off while any input bit is X or Z, so they make no claim before the operands are first driven. The bench drives only fully defined values. Each vector is held for half a clock period before sampling, so every selection stage has settled. The stimulus includes random pairs that concentrate on sign-bit and group-boundary patterns.

// File: rtl/csel_addsub.sv
module csel_addsub #(
  parameter int WIDTH = 32,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             lt_o,
  output logic             ne_o
);
  localparam int NG = WIDTH / GRP;

  logic [WIDTH-1:0] bx;
  logic [NG:0]      cg;
  logic             c_msb;

  assign bx    = b_i ^ {WIDTH{sub_i}};
  assign cg[0] = sub_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = g * GRP;
    logic [GRP-1:0] s0, s1;
    logic [GRP:0]   c0, c1;

    always_comb begin
      c0[0] = (g == 0) ? cg[0] : 1'b0;
      c1[0] = 1'b1;
      for (int i = 0; i < GRP; i++) begin
        s0[i]   = a_i[LO+i] ^ bx[LO+i] ^ c0[i];
        c0[i+1] = (a_i[LO+i] & bx[LO+i]) | (c0[i] & (a_i[LO+i] ^ bx[LO+i]));
        s1[i]   = a_i[LO+i] ^ bx[LO+i] ^ c1[i];
        c1[i+1] = (a_i[LO+i] & bx[LO+i]) | (c1[i] & (a_i[LO+i] ^ bx[LO+i]));
      end
    end

    if (g == 0) begin : g_base
      assign sum_o[LO +: GRP] = s0;
      assign cg[g+1]          = c0[GRP];
    end else begin : g_sel
      assign sum_o[LO +: GRP] = cg[g] ? s1 : s0;
      assign cg[g+1]          = cg[g] ? c1[GRP] : c0[GRP];
    end

    if (g == NG - 1) begin : g_top
      if (g == 0) begin : g_only
        assign c_msb = c0[GRP-1];
      end else begin : g_many
        assign c_msb = cg[g] ? c1[GRP-1] : c0[GRP-1];
      end
    end
  end

  assign ovf_o = c_msb ^ cg[NG];
  assign lt_o  = sum_o[WIDTH-1] ^ ovf_o;
  assign ne_o  = |sum_o;

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      a_r1_add_sum: assert (sub_i || sum_o == WIDTH'(a_i + b_i));
      a_r2_sub_diff: assert (!sub_i || sum_o == WIDTH'(a_i - b_i));
      a_r3_no_overflow: assert (ovf_o == ((a_i[WIDTH-1] == bx[WIDTH-1]) &&
                                          (sum_o[WIDTH-1] != a_i[WIDTH-1])));
      a_r4_signed_lt: assert (!sub_i || lt_o == ($signed(a_i) < $signed(b_i)));
      a_r5_not_equal: assert (!sub_i || ne_o == (a_i != b_i));
    end
  end
endmodule

// File: tb/csel_addsub_tb.sv
module csel_addsub_tb;
  localparam int PERIOD = 10;
  localparam int W = 32;

  logic [W-1:0] a, b, sum;
  logic         sub, ovf, lt, ne;
  int           checks = 0;
  int           errors = 0;
  bit           done = 0;

  csel_addsub u_dut (
    .a_i(a), .b_i(b), .sub_i(sub),
    .sum_o(sum), .ovf_o(ovf), .lt_o(lt), .ne_o(ne)
  );

  function automatic logic [W-1:0] ref_sum(logic [W-1:0] x, logic [W-1:0] y, logic s);
    return s ? x - y : x + y;
  endfunction

  function automatic logic ref_ovf(logic [W-1:0] x, logic [W-1:0] y, logic s);
    longint sx, sy, r;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    r  = s ? sx - sy : sx + sy;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: a=%h b=%h sub=%0b actual=%h expected=%h", req, what, a, b, sub, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic s, string req);
    logic [W-1:0] es;
    logic eo;
    a = x; b = y; sub = s;
    #(PERIOD/2);
    es = ref_sum(x, y, s);
    eo = ref_ovf(x, y, s);
    chk(s ? "R2" : "R1", {req, " sum"}, sum, es);
    chk("R3", {req, " ovf"}, W'(ovf), W'(eo));
    if (s) begin
      chk("R4", {req, " lt"}, W'(lt), W'($signed(x) < $signed(y)));
      chk("R5", {req, " ne"}, W'(ne), W'(x != y));
    end else begin
      chk("R6", {req, " lt"}, W'(lt), W'(es[W-1] ^ eo));
      chk("R6", {req, " ne"}, W'(ne), W'(es != 0));
    end
    #(PERIOD/2);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y;
    int unsigned seed;
    a = '0; b = '0; sub = 1'b0;
    #(PERIOD/2);
    chk("R1", "zero inputs sum", sum, '0);
    chk("R6", "zero inputs ne", W'(ne), '0);
    #(PERIOD/2);

    apply(32'h7FFFFFFF, 32'h00000002, 1'b0, "R8 max+2");
    chk("R8", "max+2 overflow", W'(ovf), 32'd1);
    apply(32'h80000000, 32'h7FFFFFFF, 1'b0, "R8 min+max");
    chk("R8", "min+max result", sum, 32'hFFFFFFFF);
    apply(32'd100, 32'd400, 1'b0, "R1 small");
    apply(32'h0000000F, 32'h1, 1'b0, "R7 grp0");
    chk("R7", "nibble carry", sum, 32'h00000010);
    apply(32'h0FFFFFFF, 32'h1, 1'b0, "R7 grp6");
    chk("R7", "long carry", sum, 32'h10000000);
    apply(32'hFFFFFFFF, 32'h1, 1'b0, "R7 wrap");
    chk("R7", "wrap no ovf", W'(ovf), '0);
    apply(32'h80000000, 32'h1, 1'b1, "R9 min-1");
    chk("R9", "min-1 ovf", W'(ovf), 32'd1);
    apply(32'h0, 32'h80000000, 1'b1, "R9 0-min");
    chk("R9", "0-min result", sum, 32'h80000000);
    apply(32'h80000000, 32'h7FFFFFFF, 1'b1, "R4 min<max");
    chk("R4", "min<max", W'(lt), 32'd1);
    apply(32'h7FFFFFFF, 32'h80000000, 1'b1, "R4 max<min");
    chk("R4", "max<min", W'(lt), '0);
    apply(32'h80000001, 32'h00000001, 1'b1, "R4 neg<pos");
    chk("R4", "neg<pos", W'(lt), 32'd1);
    apply(32'h00111000, 32'h00111000, 1'b1, "R5 equal");
    chk("R5", "equal ne", W'(ne), '0);
    apply(32'h00110101, 32'h10110101, 1'b1, "R5 differ");
    chk("R5", "differ ne", W'(ne), 32'd1);

    seed = $urandom(32'h5EED_1234);
    for (int n = 0; n < 4000; n++) begin
      x = $urandom();
      y = $urandom();
      case (n % 4)
        1: y = x;
        2: begin x[W-1:W-2] = 2'b01; y[W-1] = n[3]; end
        3: begin x = x | 32'h0FFFFFFF; y = 32'(n % 3); end
        default: ;
      endcase
      apply(x, y, n[2], "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule